// File: doc/BRIEF.md
# Diagnostic threshold flag generator

This block turns live module-health readings into latched limit-violation flags. On each sample strobe it compares a die temperature word, a supply-voltage word and an 8-bit received-margin reading against a bank of stored limits. The results are packed into four host-visible flag bytes. Two of the bytes hold alarm results and two hold warning results. Between strobes the flags hold their value, so a host read always sees one consistent sample.

Temperature and margin are two's-complement quantities and voltage is unsigned, so each comparator carries its own signedness. The limits arrive as a flat byte image in big-endian word order. The margin reading has only lower limits.

Top module: `dmon_flag_gen`

## Requirements
- R1: After reset, and after any later reset, all four flag bytes read 0x00 until the first clock edge that has `smp_vld` high.
- R2: The flag bytes change only on a clock edge where `smp_vld` is high. On any other edge they keep their previous value, whatever the sensor and limit inputs do.
- R3: Temperature is compared as a signed 16-bit value. Its high flags set when the reading is greater than the high limit, and its low flags set when the reading is less than the low limit. For example, 0xFF00 (-1 °C) is below a low limit of 0x0000.
- R4: Supply voltage is compared as an unsigned 16-bit value, using the same greater-than and less-than rules. For example, 0xF000 is above a high limit of 0x8CA0.
- R5: The margin reading is compared as a signed 8-bit value against a low alarm limit and a low warning limit only. A flag sets when the reading is less than the limit.
- R6: A reading exactly equal to a limit leaves that flag clear.
- R7: In each main flag byte, bit 7 is temperature high, bit 6 is temperature low, bit 5 is voltage high and bit 4 is voltage low. Bits 3..0 always read 0.
- R8: In each auxiliary flag byte, bit 5 is margin low and every other bit always reads 0.
- R9: The warning bytes use the same bit layout as the alarm bytes but are driven only by the warning limits. An alarm result and a warning result for the same quantity are independent.
- R10: `lim_img` holds eight 16-bit limits, and byte 0 sits at the most significant end. Limit n is formed from byte 2n (upper half) and byte 2n+1 (lower half). The limits, in order n = 0..7, are: temperature high alarm, temperature low alarm, temperature high warning, temperature low warning, then voltage high alarm, voltage low alarm, voltage high warning and voltage low warning.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| smp_vld | input | 1 | Sample strobe; the comparisons are captured on edges where this is high |
| temp_val | input | 16 | Temperature reading, signed, 1/256 °C per LSB |
| vcc_val | input | 16 | Supply reading, unsigned, 100 µV per LSB |
| marg_val | input | 8 | Received margin reading, signed, 0.2 dB per LSB |
| lim_img | input | 128 | Temperature and voltage limit image, big-endian (see R10) |
| marg_lo_alm | input | 8 | Margin low alarm limit, signed |
| marg_lo_wrn | input | 8 | Margin low warning limit, signed |
| alm_main | output | 8 | Temperature and voltage alarm flags |
| alm_aux | output | 8 | Margin alarm flag |
| wrn_main | output | 8 | Temperature and voltage warning flags |
| wrn_aux | output | 8 | Margin warning flag |

## Verification
The cases that are hardest to reach are those where the signedness of a comparator decides the result. These are readings whose top bit is set. A negative temperature read as unsigned would look hot, and a high supply word read as signed would look low. The vector table deliberately places such readings between limits so that only the correct signedness gives the expected byte. The byte order and word order of the limit image are reached by reloading the image with a limit whose two bytes, if swapped, would equal the reading exactly. That flag then shows whether the limit was decoded in the right place.

// File: rtl/dmon_pkg.sv
package dmon_pkg;

    parameter int WORD_W   = 16;
    parameter int MARG_W   = 8;
    parameter int BYTE_W   = 8;
    parameter int SENSORS  = 2;
    parameter int LIM_PER  = 4;

    localparam int WORD_BYTES = WORD_W / BYTE_W;
    localparam int NUM_WORDS  = SENSORS * LIM_PER;
    localparam int IMG_W      = NUM_WORDS * WORD_W;

    // word slots inside one sensor's group of limits
    localparam int SLOT_HI_ALM = 0;
    localparam int SLOT_LO_ALM = 1;
    localparam int SLOT_HI_WRN = 2;
    localparam int SLOT_LO_WRN = 3;

    // sensor group base index
    localparam int GRP_TEMP = 0;
    localparam int GRP_VCC  = 1;

    // bit positions in the host-visible bytes
    localparam int POS_T_HI = 7;
    localparam int POS_T_LO = 6;
    localparam int POS_V_HI = 5;
    localparam int POS_V_LO = 4;
    localparam int POS_M_LO = 5;

    typedef logic [WORD_W-1:0] word_t;
    typedef logic [BYTE_W-1:0] byte_t;

    typedef struct packed {
        word_t hi_alm;
        word_t lo_alm;
        word_t hi_wrn;
        word_t lo_wrn;
    } lim_set_t;

    typedef struct packed {
        logic hi_alm;
        logic lo_alm;
        logic hi_wrn;
        logic lo_wrn;
    } sens_trip_t;

    typedef struct packed {
        logic t_hi;
        logic t_lo;
        logic v_hi;
        logic v_lo;
        logic m_lo;
    } trip_t;

    typedef struct packed {
        byte_t alm_main;
        byte_t alm_aux;
        byte_t wrn_main;
        byte_t wrn_aux;
    } flag_bank_t;

    function automatic byte_t pack_main(input trip_t t);
        byte_t b;
        b = '0;
        b[POS_T_HI] = t.t_hi;
        b[POS_T_LO] = t.t_lo;
        b[POS_V_HI] = t.v_hi;
        b[POS_V_LO] = t.v_lo;
        return b;
    endfunction

    function automatic byte_t pack_aux(input trip_t t);
        byte_t b;
        b = '0;
        b[POS_M_LO] = t.m_lo;
        return b;
    endfunction

endpackage

// File: rtl/dmon_lim_unpack.sv
module dmon_lim_unpack
    import dmon_pkg::*;
(
    input  logic [IMG_W-1:0] lim_img,
    output lim_set_t         temp_lim,
    output lim_set_t         vcc_lim
);

    word_t words [NUM_WORDS];

    // byte k sits at the top end of the image; word n = {byte 2n, byte 2n+1}
    for (genvar w = 0; w < NUM_WORDS; w++) begin : g_word
        for (genvar b = 0; b < WORD_BYTES; b++) begin : g_byte
            localparam int K = w * WORD_BYTES + b;
            assign words[w][WORD_W-1-b*BYTE_W -: BYTE_W] = lim_img[IMG_W-1-K*BYTE_W -: BYTE_W];
        end
    end

    assign temp_lim.hi_alm = words[GRP_TEMP*LIM_PER + SLOT_HI_ALM];
    assign temp_lim.lo_alm = words[GRP_TEMP*LIM_PER + SLOT_LO_ALM];
    assign temp_lim.hi_wrn = words[GRP_TEMP*LIM_PER + SLOT_HI_WRN];
    assign temp_lim.lo_wrn = words[GRP_TEMP*LIM_PER + SLOT_LO_WRN];

    assign vcc_lim.hi_alm  = words[GRP_VCC*LIM_PER + SLOT_HI_ALM];
    assign vcc_lim.lo_alm  = words[GRP_VCC*LIM_PER + SLOT_LO_ALM];
    assign vcc_lim.hi_wrn  = words[GRP_VCC*LIM_PER + SLOT_HI_WRN];
    assign vcc_lim.lo_wrn  = words[GRP_VCC*LIM_PER + SLOT_LO_WRN];

endmodule

// File: rtl/dmon_cmp.sv
module dmon_cmp #(
    parameter int W         = 16,
    parameter bit IS_SIGNED = 1'b0,
    parameter bit CHK_HIGH  = 1'b1
) (
    input  logic [W-1:0] val,
    input  logic [W-1:0] lim,
    output logic         trip
);

    logic above;
    logic below;

    if (IS_SIGNED) begin : g_signed
        assign above = $signed(val) > $signed(lim);
        assign below = $signed(val) < $signed(lim);
    end else begin : g_unsigned
        assign above = val > lim;
        assign below = val < lim;
    end

    if (CHK_HIGH) begin : g_high
        assign trip = above;
    end else begin : g_low
        assign trip = below;
    end

endmodule

// File: rtl/dmon_sens_eval.sv
module dmon_sens_eval
    import dmon_pkg::*;
#(
    parameter bit IS_SIGNED = 1'b0
) (
    input  word_t      val,
    input  lim_set_t   lim,
    output sens_trip_t trip
);

    dmon_cmp #(.W(WORD_W), .IS_SIGNED(IS_SIGNED), .CHK_HIGH(1'b1)) u_hi_alm (
        .val(val), .lim(lim.hi_alm), .trip(trip.hi_alm)
    );

    dmon_cmp #(.W(WORD_W), .IS_SIGNED(IS_SIGNED), .CHK_HIGH(1'b0)) u_lo_alm (
        .val(val), .lim(lim.lo_alm), .trip(trip.lo_alm)
    );

    dmon_cmp #(.W(WORD_W), .IS_SIGNED(IS_SIGNED), .CHK_HIGH(1'b1)) u_hi_wrn (
        .val(val), .lim(lim.hi_wrn), .trip(trip.hi_wrn)
    );

    dmon_cmp #(.W(WORD_W), .IS_SIGNED(IS_SIGNED), .CHK_HIGH(1'b0)) u_lo_wrn (
        .val(val), .lim(lim.lo_wrn), .trip(trip.lo_wrn)
    );

endmodule

// File: rtl/dmon_flag_gen.sv
module dmon_flag_gen
    import dmon_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              smp_vld,
    input  logic [WORD_W-1:0] temp_val,
    input  logic [WORD_W-1:0] vcc_val,
    input  logic [MARG_W-1:0] marg_val,
    input  logic [IMG_W-1:0]  lim_img,
    input  logic [MARG_W-1:0] marg_lo_alm,
    input  logic [MARG_W-1:0] marg_lo_wrn,
    output logic [BYTE_W-1:0] alm_main,
    output logic [BYTE_W-1:0] alm_aux,
    output logic [BYTE_W-1:0] wrn_main,
    output logic [BYTE_W-1:0] wrn_aux
);

    lim_set_t   temp_lim;
    lim_set_t   vcc_lim;
    sens_trip_t temp_trip;
    sens_trip_t vcc_trip;
    logic       marg_alm_trip;
    logic       marg_wrn_trip;
    trip_t      alm_nxt, wrn_nxt;
    trip_t      alm_q, wrn_q;
    flag_bank_t bank;

    dmon_lim_unpack u_unpack (
        .lim_img (lim_img),
        .temp_lim(temp_lim),
        .vcc_lim (vcc_lim)
    );

    dmon_sens_eval #(.IS_SIGNED(1'b1)) u_temp (
        .val (temp_val),
        .lim (temp_lim),
        .trip(temp_trip)
    );

    dmon_sens_eval #(.IS_SIGNED(1'b0)) u_vcc (
        .val (vcc_val),
        .lim (vcc_lim),
        .trip(vcc_trip)
    );

    dmon_cmp #(.W(MARG_W), .IS_SIGNED(1'b1), .CHK_HIGH(1'b0)) u_marg_alm (
        .val(marg_val), .lim(marg_lo_alm), .trip(marg_alm_trip)
    );

    dmon_cmp #(.W(MARG_W), .IS_SIGNED(1'b1), .CHK_HIGH(1'b0)) u_marg_wrn (
        .val(marg_val), .lim(marg_lo_wrn), .trip(marg_wrn_trip)
    );

    always_comb begin
        alm_nxt.t_hi = temp_trip.hi_alm;
        alm_nxt.t_lo = temp_trip.lo_alm;
        alm_nxt.v_hi = vcc_trip.hi_alm;
        alm_nxt.v_lo = vcc_trip.lo_alm;
        alm_nxt.m_lo = marg_alm_trip;
        wrn_nxt.t_hi = temp_trip.hi_wrn;
        wrn_nxt.t_lo = temp_trip.lo_wrn;
        wrn_nxt.v_hi = vcc_trip.hi_wrn;
        wrn_nxt.v_lo = vcc_trip.lo_wrn;
        wrn_nxt.m_lo = marg_wrn_trip;
    end

    // only meaningful flag bits are stored; reserved bits are packed as constants
    always_ff @(posedge clk) begin
        if (rst) begin
            alm_q <= '0;
            wrn_q <= '0;
        end else if (smp_vld) begin
            alm_q <= alm_nxt;
            wrn_q <= wrn_nxt;
        end
    end

    always_comb begin
        bank.alm_main = pack_main(alm_q);
        bank.alm_aux  = pack_aux(alm_q);
        bank.wrn_main = pack_main(wrn_q);
        bank.wrn_aux  = pack_aux(wrn_q);
    end

    assign alm_main = bank.alm_main;
    assign alm_aux  = bank.alm_aux;
    assign wrn_main = bank.wrn_main;
    assign wrn_aux  = bank.wrn_aux;

endmodule

// File: rtl/dmon_flag_gen_chk.sv
module dmon_flag_gen_chk (
    input logic        clk,
    input logic        rst,
    input logic        smp_vld,
    input logic [15:0] temp_val,
    input logic [15:0] vcc_val,
    input logic [7:0]  marg_val,
    input logic [15:0] t_hi_alm,
    input logic [15:0] t_lo_wrn,
    input logic [15:0] v_hi_alm,
    input logic [15:0] v_lo_alm,
    input logic [7:0]  m_lo_alm,
    input logic [7:0]  alm_main,
    input logic [7:0]  alm_aux,
    input logic [7:0]  wrn_main,
    input logic [7:0]  wrn_aux
);

    // R1
    reset_clear_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> ({alm_main, alm_aux, wrn_main, wrn_aux} == 32'h0));

    // R2
    hold_no_strobe_chk: assert property (@(posedge clk) disable iff (rst)
        !smp_vld |=> $stable({alm_main, alm_aux, wrn_main, wrn_aux}));

    // R3
    temp_hi_alm_chk: assert property (@(posedge clk) disable iff (rst)
        (smp_vld && ($signed(temp_val) > $signed(t_hi_alm))) |=> alm_main[7]);

    // R3
    temp_lo_wrn_chk: assert property (@(posedge clk) disable iff (rst)
        (smp_vld && ($signed(temp_val) < $signed(t_lo_wrn))) |=> wrn_main[6]);

    // R4
    vcc_hi_alm_chk: assert property (@(posedge clk) disable iff (rst)
        (smp_vld && (vcc_val > v_hi_alm)) |=> alm_main[5]);

    // R4
    vcc_lo_alm_chk: assert property (@(posedge clk) disable iff (rst)
        (smp_vld && (vcc_val < v_lo_alm)) |=> alm_main[4]);

    // R5
    marg_lo_alm_chk: assert property (@(posedge clk) disable iff (rst)
        (smp_vld && ($signed(marg_val) < $signed(m_lo_alm))) |=> alm_aux[5]);

    // R6
    temp_equal_chk: assert property (@(posedge clk) disable iff (rst)
        (smp_vld && (temp_val == t_hi_alm)) |=> !alm_main[7]);

    // R7
    main_rsvd_chk: assert property (@(posedge clk) disable iff (rst)
        (alm_main[3:0] == 4'h0) && (wrn_main[3:0] == 4'h0));

    // R8
    aux_rsvd_chk: assert property (@(posedge clk) disable iff (rst)
        ((alm_aux & 8'hDF) == 8'h00) && ((wrn_aux & 8'hDF) == 8'h00));

endmodule

bind dmon_flag_gen dmon_flag_gen_chk u_chk (
    .clk     (clk),
    .rst     (rst),
    .smp_vld (smp_vld),
    .temp_val(temp_val),
    .vcc_val (vcc_val),
    .marg_val(marg_val),
    .t_hi_alm(lim_img[127:112]),
    .t_lo_wrn(lim_img[79:64]),
    .v_hi_alm(lim_img[63:48]),
    .v_lo_alm(lim_img[47:32]),
    .m_lo_alm(marg_lo_alm),
    .alm_main(alm_main),
    .alm_aux (alm_aux),
    .wrn_main(wrn_main),
    .wrn_aux (wrn_aux)
);

// File: tb/dmon_flag_gen_tb_top.sv
`timescale 1ns/1ps
module dmon_flag_gen_tb_top;

    logic         clk = 1'b0;
    logic         rst;
    logic         smp_vld;
    logic [15:0]  temp_val;
    logic [15:0]  vcc_val;
    logic [7:0]   marg_val;
    logic [127:0] lim_img;
    logic [7:0]   marg_lo_alm;
    logic [7:0]   marg_lo_wrn;
    logic [7:0]   alm_main, alm_aux, wrn_main, wrn_aux;

    int total = 0;
    int bad   = 0;

    always #4 clk = ~clk;

    dmon_flag_gen dut_i (
        .clk(clk), .rst(rst), .smp_vld(smp_vld),
        .temp_val(temp_val), .vcc_val(vcc_val), .marg_val(marg_val),
        .lim_img(lim_img), .marg_lo_alm(marg_lo_alm), .marg_lo_wrn(marg_lo_wrn),
        .alm_main(alm_main), .alm_aux(alm_aux),
        .wrn_main(wrn_main), .wrn_aux(wrn_aux)
    );

    // limits: T hiA 80C, loA -10C, hiW 70C, loW 0C; V hiA, loA, hiW, loW
    localparam logic [127:0] IMG_A = 128'h5000_F600_4600_0000_8CA0_7530_88B8_7918;
    // R10: temp hiW = bytes 00,19 and vcc loW = 80,00
    localparam logic [127:0] IMG_B = 128'h5000_F600_0019_0000_8CA0_7530_88B8_8000;

    // {temp, vcc, marg, alm_main, alm_aux, wrn_main, wrn_aux}
    localparam int NV = 16;
    localparam logic [71:0] VECS [NV] = '{
        {16'h1900, 16'h80E8, 8'h10, 8'h00, 8'h00, 8'h00, 8'h00}, // nominal
        {16'h5001, 16'h80E8, 8'h10, 8'h80, 8'h00, 8'h80, 8'h00}, // R3 R7 hot
        {16'hF500, 16'h80E8, 8'h10, 8'h40, 8'h00, 8'h40, 8'h00}, // R3 cold signed
        {16'hFF00, 16'h80E8, 8'h10, 8'h00, 8'h00, 8'h40, 8'h00}, // R3 R9 warn only
        {16'h5000, 16'h80E8, 8'h10, 8'h00, 8'h00, 8'h80, 8'h00}, // R6 equal hiA
        {16'h1900, 16'h8CA1, 8'h10, 8'h20, 8'h00, 8'h20, 8'h00}, // R4 high
        {16'h1900, 16'h7000, 8'h10, 8'h10, 8'h00, 8'h10, 8'h00}, // R4 low
        {16'h1900, 16'h8CA0, 8'h10, 8'h00, 8'h00, 8'h20, 8'h00}, // R6 equal vcc
        {16'h1900, 16'hF000, 8'h10, 8'h20, 8'h00, 8'h20, 8'h00}, // R4 unsigned top bit
        {16'h1900, 16'h80E8, 8'hF5, 8'h00, 8'h20, 8'h00, 8'h20}, // R5 R8 low
        {16'h1900, 16'h80E8, 8'hFF, 8'h00, 8'h00, 8'h00, 8'h20}, // R5 R9 warn only
        {16'h1900, 16'h80E8, 8'h7F, 8'h00, 8'h00, 8'h00, 8'h00}, // R5 max positive
        {16'h1900, 16'h80E8, 8'hF6, 8'h00, 8'h00, 8'h00, 8'h20}, // R6 equal margin
        {16'h1900, 16'h80E8, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00}, // R6 equal loW
        {16'h7FFF, 16'h0000, 8'h80, 8'h90, 8'h20, 8'h90, 8'h20}, // R7 R8 combined
        {16'h8000, 16'hFFFF, 8'h10, 8'h60, 8'h00, 8'h60, 8'h00}  // R3 R4 extremes
    };

    task automatic chk(input string req, input string what,
                       input logic [7:0] act, input logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s: actual=%02h expected=%02h", req, what, act, exp);
        end
    endtask

    task automatic chk_all(input string req, input logic [31:0] exp);
        chk(req, "alm_main", alm_main, exp[31:24]);
        chk(req, "alm_aux",  alm_aux,  exp[23:16]);
        chk(req, "wrn_main", wrn_main, exp[15:8]);
        chk(req, "wrn_aux",  wrn_aux,  exp[7:0]);
    endtask

    task automatic drive(input logic [15:0] t, input logic [15:0] v, input logic [7:0] m);
        temp_val = t;
        vcc_val  = v;
        marg_val = m;
    endtask

    // strobe for one edge, then look one half period after it
    task automatic sample(input logic [15:0] t, input logic [15:0] v, input logic [7:0] m);
        @(negedge clk);
        drive(t, v, m);
        smp_vld = 1'b1;
        @(negedge clk);
        smp_vld = 1'b0;
    endtask

    initial begin
        #(200000 * 8);
        total++;
        bad++;
        $display("FAIL watchdog: actual=running expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        rst         = 1'b1;
        smp_vld     = 1'b0;
        lim_img     = IMG_A;
        marg_lo_alm = 8'hF6;
        marg_lo_wrn = 8'h00;
        drive(16'h7FFF, 16'h0000, 8'h80);
        repeat (3) @(negedge clk);
        rst = 1'b0;
        repeat (2) @(negedge clk);
        // R1: tripping inputs present but no strobe yet
        chk_all("R1", 32'h0);

        for (int i = 0; i < NV; i++) begin
            sample(VECS[i][71:56], VECS[i][55:40], VECS[i][39:32]);
            chk_all($sformatf("R3-9 vec%0d", i), VECS[i][31:0]);
        end

        // R2: all set, then inputs go nominal with no strobe
        sample(16'h7FFF, 16'h0000, 8'h80);
        @(negedge clk);
        drive(16'h1900, 16'h80E8, 8'h10);
        lim_img = IMG_B;
        repeat (3) @(negedge clk);
        chk_all("R2", 32'h90209020);
        lim_img = IMG_A;
        sample(16'h1900, 16'h80E8, 8'h10);
        chk_all("R2", 32'h0);

        // R10: byte and word order of the limit image
        lim_img = IMG_B;
        sample(16'h1900, 16'h7A00, 8'h10);
        chk_all("R10", 32'h00009000);
        lim_img = IMG_A;
        sample(16'h1900, 16'h7A00, 8'h10);
        chk_all("R10", 32'h0);

        // R1: reset later in the run clears the flags
        sample(16'h7FFF, 16'h0000, 8'h80);
        chk_all("R1", 32'h90209020);
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk_all("R1", 32'h0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule